// File: doc/BRIEF.md
# Status Change History Recorder

This block keeps a time-stamped log of status transitions. It watches four 4-bit status words:

- the front-end emulation status;
- the front-end monitor input;
- the status sent to the local trigger controller;
- the status sent to the central trigger controller.

When any of them differs from its value in the previous clock, the block writes one 64-bit record into a circular memory of 4096 entries. The record holds the current orbit and bunch-crossing count, plus a few run-context bits. Software reads the log through a simple address/data read port. A write-pointer readback and a wrap flag show where the newest record sits and how many entries are valid.

Time is kept by two free-running counters. The bunch-crossing counter advances on every clock. The bunch-zero marker returns it to zero and advances the orbit counter. A synchronous reset restarts the counters, empties the log logically and takes the present statuses as the new baseline.

Top module: `status_history_log`

## Requirements
- R1: In a clock where the concatenated status inputs differ from their values sampled at the previous clock (and reset is low), one record is written at address `wr_ptr`, and `wr_ptr` advances by one at that edge.
- R2: When several status words change in the same clock, exactly one record is written and `wr_ptr` advances by exactly one.
- R3: In a clock where no status word changes, nothing is written and `wr_ptr` is unchanged.
- R4: Record layout:
  - bits [63:32] are the orbit count and bits [31:20] the bunch-crossing count, both as held in the clock of the change;
  - bit 19 is `run_on`, bit 18 is `sel_local`, bit 17 is `sel_central`, and bit 16 is 0;
  - bits [15:12], [11:8], [7:4] and [3:0] are the new values of `st_fe`, `st_mon`, `st_loc` and `st_cen`.
- R5: The bunch-crossing count rises by one every clock, modulo 4096. In a clock with `bc0` high, the next count is 0 and the orbit count rises by one, modulo 2^32.
- R6: After a write to the last address (all ones), `wr_ptr` returns to 0 and later records overwrite the oldest ones.
- R7: `wrapped` goes high at the first rollover of `wr_ptr` and stays high until reset.
- R8: Synchronous reset `rst`:
  - clears both counters, `wr_ptr` and `wrapped`;
  - writes no record;
  - takes the statuses present during reset as the comparison baseline, so unchanged statuses log nothing afterwards.
- R9: `rd_data` shows the entry at the `rd_addr` sampled at the previous clock edge. If the same entry is written at that edge, the old content is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bc0 | input | 1 | Bunch-zero marker, one-clock pulse |
| run_on | input | 1 | Run in progress, stored in record bit 19 |
| sel_local | input | 1 | Local trigger controller selected, record bit 18 |
| sel_central | input | 1 | Central trigger controller selected, record bit 17 |
| st_fe | input | 4 | Front-end emulation status |
| st_mon | input | 4 | Front-end monitor status |
| st_loc | input | 4 | Status sent to local trigger controller |
| st_cen | input | 4 | Status sent to central trigger controller |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 64 | Record at the previously sampled read address |
| wr_ptr | output | ADDR_W | Address the next record will be written to |
| wrapped | output | 1 | Log has rolled over at least once since reset |

## Verification
The stimulus covers several patterns:

- each status word changing alone, which shows that every field is compared and lands in its own slot;
- all four words changing together, which separates one record per clock from one record per field;
- long stretches without change, which show that steady input logs nothing;
- a stretch of more than 4096 clocks with no `bc0`, so the bunch-crossing stamp is seen to wrap;
- more changes than the log holds, which exposes the pointer rollover, the overwrite of the oldest entries and the sticky wrap flag;
- a reset in mid-run with statuses held, to show the new baseline and the cleared time stamp.

A behavioural model in the bench predicts the pointer, the flag and the contents of the entry being read, and these are compared with the outputs on every clock.

// File: rtl/status_history_log.sv
module status_history_log #(
  parameter int ADDR_W  = 12,
  parameter int ORBIT_W = 32,
  parameter int BX_W    = 12,
  parameter int ST_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bc0,
  input  logic              run_on,
  input  logic              sel_local,
  input  logic              sel_central,
  input  logic [ST_W-1:0]   st_fe,
  input  logic [ST_W-1:0]   st_mon,
  input  logic [ST_W-1:0]   st_loc,
  input  logic [ST_W-1:0]   st_cen,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ORBIT_W+BX_W+4+4*ST_W-1:0] rd_data,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              wrapped
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int STS_W = 4 * ST_W;
  localparam int REC_W = ORBIT_W + BX_W + 4 + STS_W;

  logic [STS_W-1:0]   st_now, st_prev;
  logic [ORBIT_W-1:0] orbit_cnt;
  logic [BX_W-1:0]    bx_cnt;
  logic [REC_W-1:0]   rec;
  logic               log_en;
  logic [REC_W-1:0]   mem [DEPTH];

  assign st_now = {st_fe, st_mon, st_loc, st_cen};
  assign log_en = !rst && (st_now != st_prev);
  assign rec    = {orbit_cnt, bx_cnt, run_on, sel_local, sel_central, 1'b0, st_now};

  always_ff @(posedge clk) st_prev <= st_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      orbit_cnt <= '0;
      bx_cnt    <= '0;
    end else if (bc0) begin
      orbit_cnt <= orbit_cnt + 1'b1;
      bx_cnt    <= '0;
    end else begin
      bx_cnt    <= bx_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      wrapped <= 1'b0;
    end else if (log_en) begin
      wr_ptr <= wr_ptr + 1'b1;
      if (&wr_ptr) wrapped <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (log_en) mem[wr_ptr] <= rec;
    rd_data <= mem[rd_addr];
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    log_en |=> wr_ptr == $past(wr_ptr) + 1'b1);            // R1
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !log_en |=> $stable(wr_ptr));                          // R3
  AST_BX_ZERO: assert property (@(posedge clk) disable iff (rst)
    bc0 |=> bx_cnt == '0);                                 // R5
  AST_WRAP_SET: assert property (@(posedge clk) disable iff (rst)
    (log_en && &wr_ptr) |=> (wrapped && wr_ptr == '0));    // R6
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    wrapped |=> wrapped);                                  // R7
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (wr_ptr == '0 && !wrapped && bx_cnt == '0));   // R8

endmodule

// File: tb/status_history_log_bench.sv
module status_history_log_bench;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 0;
  logic rst = 1, bc0 = 0, run_on = 0, sel_local = 0, sel_central = 0;
  logic [3:0] st_fe = 4'h1, st_mon = 4'h2, st_loc = 4'h3, st_cen = 4'h4;
  logic [AW-1:0] rd_addr = '0;
  logic [63:0] rd_data;
  logic [AW-1:0] wr_ptr;
  logic wrapped;

  always #5 clk = ~clk;

  status_history_log #(.ADDR_W(AW)) u_status_history_log (
    .clk(clk), .rst(rst), .bc0(bc0), .run_on(run_on), .sel_local(sel_local),
    .sel_central(sel_central), .st_fe(st_fe), .st_mon(st_mon), .st_loc(st_loc),
    .st_cen(st_cen), .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr),
    .wrapped(wrapped));

  int compared = 0, mismatched = 0, cyc = 0;
  bit started = 0;

  logic [31:0] m_orbit;
  logic [11:0] m_bx;
  logic [15:0] m_prev;
  int          m_ptr = 0;
  bit          m_wrap = 0;
  logic [63:0] m_mem [int];
  logic [63:0] rd_exp;
  bit          rd_exp_v = 0;

  always @(posedge clk) begin
    logic [15:0] now;
    now = {st_fe, st_mon, st_loc, st_cen};
    rd_exp_v = m_mem.exists(int'(rd_addr));
    if (rd_exp_v) rd_exp = m_mem[int'(rd_addr)];
    if (rst) begin
      m_orbit = 0; m_bx = 0; m_ptr = 0; m_wrap = 0;
    end else begin
      if (now != m_prev) begin
        m_mem[m_ptr] = {m_orbit, m_bx, run_on, sel_local, sel_central, 1'b0, now};
        m_ptr = m_ptr + 1;
        if (m_ptr == DEPTH) begin m_ptr = 0; m_wrap = 1; end
      end
      if (bc0) begin m_bx = 0; m_orbit = m_orbit + 1; end
      else m_bx = m_bx + 1;
    end
    m_prev = now;
    started = 1;
    cyc++;
  end

  always @(negedge clk) begin
    if (started) begin
      compared++;
      if (int'(wr_ptr) != m_ptr) begin
        mismatched++;
        $display("FAIL R1 R2 R3 R6 R8 wr_ptr actual %0d expected %0d at cycle %0d", wr_ptr, m_ptr, cyc);
      end
      compared++;
      if (wrapped != m_wrap) begin
        mismatched++;
        $display("FAIL R7 R8 wrapped actual %0b expected %0b at cycle %0d", wrapped, m_wrap, cyc);
      end
      if (rd_exp_v) begin
        compared++;
        if (rd_data !== rd_exp) begin
          mismatched++;
          $display("FAIL R4 R5 R9 rd_data actual %h expected %h at cycle %0d", rd_data, rd_exp, cyc);
        end
      end
    end
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bc0 = 0;
      rd_addr = rd_addr + 1'b1;
    end
  endtask

  task automatic set_st(logic [3:0] a, logic [3:0] b, logic [3:0] c, logic [3:0] d);
    @(negedge clk);
    st_fe = a; st_mon = b; st_loc = c; st_cen = d;
    rd_addr = rd_addr + 1'b1;
    bc0 = 0;
  endtask

  task automatic pulse_bc0;
    @(negedge clk);
    bc0 = 1;
    rd_addr = rd_addr + 1'b1;
  endtask

  initial begin
    step(3);
    rst = 0;
    step(4);                                 // R3 R8: baseline held, no records
    run_on = 1; sel_local = 1;
    set_st(4'h5, 4'h2, 4'h3, 4'h4); step(2); // R1 front-end field
    set_st(4'h5, 4'h7, 4'h3, 4'h4); step(1); // R4 monitor field
    pulse_bc0; step(3);                      // R5 orbit step
    set_st(4'h5, 4'h7, 4'h9, 4'h4);          // R4 local field
    set_st(4'h5, 4'h7, 4'h9, 4'hC);          // back-to-back, central field
    sel_local = 0; sel_central = 1;
    pulse_bc0;
    set_st(4'hA, 4'hB, 4'hC, 4'hD); step(5); // R2 all change at once
    step(4200);                              // R5 bx wraps without bc0
    set_st(4'h0, 4'hB, 4'hC, 4'hD); step(3);
    for (int k = 0; k < 40; k++) begin       // R6 R7 rollover, overwrite
      set_st(4'(k), 4'(k + 3), 4'hC, 4'(k * 5));
      if (k % 7 == 0) pulse_bc0;
    end
    step(2 * DEPTH + 3);                     // R9 full read sweep
    run_on = 0;
    @(negedge clk); rst = 1; rd_addr = rd_addr + 1'b1;
    st_fe = 4'hF;                            // change during reset logs nothing
    step(2);
    rst = 0;
    step(5);                                 // R8 baseline taken in reset
    set_st(4'hE, 4'hB, 4'hC, 4'h1); step(2 * DEPTH);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule